// File: doc/BRIEF.md
# Memory Controller Profiling Counters

This block sits beside a memory controller and passively watches its read-address and write-address channels. While software holds profiling running, every completed address handshake whose transaction ID falls inside a programmable ID group adds one to an access counter and adds the burst's byte total to a byte counter. Reads and writes are counted separately. A fifth counter accumulates every clock cycle in which the controller reports that it is not idle. That includes arbitration, command and bank-management cycles as well as data beats, and this counter applies no ID filter.

The block never drives a ready signal and exerts no back-pressure. A transfer counts only in the cycle where the controller's `valid` and `ready` are both high, so a request held under back-pressure is counted exactly once, when it is accepted. Software starts profiling with an enable, pauses it with a freeze so the values can be read while they stay steady, and zeroes everything with a clear. The counters are register outputs and reflect a cycle's events one clock later. They saturate at their maximum value and raise a sticky overflow flag.

Top module: `prof_mon`

## Requirements
- R1: After reset all five counters and the overflow flag read zero.
- R2: The read-access counter increases by one for each cycle with `ar_valid` and `ar_ready` both high and a matching `ar_id` while profiling runs, and the new value appears one clock later.
- R3: The write-access counter increases by one for each matching `aw_valid`/`aw_ready` handshake while profiling runs.
- R4: Each counted access adds (len+1) * 2^size bytes to its byte counter, where len is the 8-bit beat count minus one and size is the 3-bit log2 of the beat width in bytes.
- R5: An ID matches when ((id XOR id_sel) AND id_mask) is zero. A mask bit of 1 means that bit is compared. Non-matching handshakes change no counter.
- R6: A cycle with valid high and ready low counts nothing.
- R7: The busy counter increases by one for every running cycle with `ctrl_idle` low, independent of any ID or handshake.
- R8: Profiling runs only when `prof_en` is 1 and `prof_freeze` is 0. Otherwise all counters hold their values.
- R9: `prof_clear` zeroes all five counters and the overflow flag on the next clock and takes priority over counting.
- R10: A counter whose increment would pass its maximum stops at the maximum, and `ovf_flag` sets and stays set until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prof_en | input | 1 | Profiling enable |
| prof_freeze | input | 1 | Pause counting, hold values |
| prof_clear | input | 1 | Synchronous clear of counters and flag |
| id_sel | input | ID_W | ID to match |
| id_mask | input | ID_W | Compare mask, 1 = bit compared |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | 8 | Read burst beats minus one |
| ar_size | input | 3 | Read beat size, log2 bytes |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | 8 | Write burst beats minus one |
| aw_size | input | 3 | Write beat size, log2 bytes |
| ctrl_idle | input | 1 | Controller state machine idle |
| rd_acc_cnt | output | CNT_W | Read accesses |
| wr_acc_cnt | output | CNT_W | Write accesses |
| rd_byte_cnt | output | CNT_W | Bytes read |
| wr_byte_cnt | output | CNT_W | Bytes written |
| busy_cnt | output | CNT_W | Non-idle cycles |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check several rules on every cycle. Counters never decrease except through a clear, and a clear lands as zero. A saturated counter stays at its maximum, and the overflow flag is sticky. All counters hold while profiling is stopped. The read-access counter ignores cycles without a completed handshake, and the busy counter ignores idle cycles. Other behaviours need the bench's scenarios with known expected totals: the exact byte arithmetic, ID matching under different masks, rejection of foreign IDs, the priority of a clear over a simultaneous handshake, and the clipping point on a narrowed counter.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int LEN_W   = 8;
  localparam int SIZE_W  = 3;
  localparam int BYTES_W = LEN_W + (1 << SIZE_W) - 1 + 1;

  function automatic logic [BYTES_W-1:0] burst_bytes(
    input logic [LEN_W-1:0]  len,
    input logic [SIZE_W-1:0] size
  );
    logic [BYTES_W-1:0] beats;
    beats = BYTES_W'(len) + BYTES_W'(1);
    return beats << size;
  endfunction
endpackage

// File: rtl/prof_id_filter.sv
module prof_id_filter
  import prof_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic               run,
  input  logic               valid,
  input  logic               ready,
  input  logic [ID_W-1:0]    id,
  input  logic [ID_W-1:0]    id_sel,
  input  logic [ID_W-1:0]    id_mask,
  input  logic [LEN_W-1:0]   len,
  input  logic [SIZE_W-1:0]  size,
  output logic               hit,
  output logic [BYTES_W-1:0] bytes
);
  logic id_ok;
  always_comb begin
    id_ok = ((id ^ id_sel) & id_mask) == '0;
    hit   = run && valid && ready && id_ok;
    bytes = burst_bytes(len, size);
  end
endmodule

// File: rtl/prof_sat_cnt.sv
module prof_sat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt,
  output logic             sat_evt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W:0] sum;

  always_comb begin
    sum     = {1'b0, cnt} + (W+1)'(inc);
    sat_evt = inc_en && !clr && sum[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (inc_en)  cnt <= sum[W] ? MAX : sum[W-1:0];
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R9
  AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !clr) |=> cnt == MAX); // R10
  AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt)); // R2
endmodule

// File: rtl/prof_mon.sv
module prof_mon
  import prof_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prof_en,
  input  logic              prof_freeze,
  input  logic              prof_clear,
  input  logic [ID_W-1:0]   id_sel,
  input  logic [ID_W-1:0]   id_mask,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic              ctrl_idle,
  output logic [CNT_W-1:0]  rd_acc_cnt,
  output logic [CNT_W-1:0]  wr_acc_cnt,
  output logic [CNT_W-1:0]  rd_byte_cnt,
  output logic [CNT_W-1:0]  wr_byte_cnt,
  output logic [CNT_W-1:0]  busy_cnt,
  output logic              ovf_flag
);
  localparam int NCH  = 2;
  localparam int NCNT = 5;

  logic                run;
  logic                ch_valid [NCH];
  logic                ch_ready [NCH];
  logic [ID_W-1:0]     ch_id    [NCH];
  logic [LEN_W-1:0]    ch_len   [NCH];
  logic [SIZE_W-1:0]   ch_size  [NCH];
  logic                ch_hit   [NCH];
  logic [BYTES_W-1:0]  ch_bytes [NCH];
  logic                c_en     [NCNT];
  logic [BYTES_W-1:0]  c_inc    [NCNT];
  logic [CNT_W-1:0]    c_val    [NCNT];
  logic [NCNT-1:0]     c_sat;

  always_comb begin
    run = prof_en && !prof_freeze;
    ch_valid[0] = ar_valid; ch_ready[0] = ar_ready; ch_id[0] = ar_id;
    ch_len[0]   = ar_len;   ch_size[0]  = ar_size;
    ch_valid[1] = aw_valid; ch_ready[1] = aw_ready; ch_id[1] = aw_id;
    ch_len[1]   = aw_len;   ch_size[1]  = aw_size;
    // index: 0 rd acc, 1 wr acc, 2 rd bytes, 3 wr bytes, 4 busy
    for (int c = 0; c < NCH; c++) begin
      c_en[c]      = ch_hit[c];
      c_inc[c]     = BYTES_W'(1);
      c_en[c+2]    = ch_hit[c];
      c_inc[c+2]   = ch_bytes[c];
    end
    c_en[4]  = run && !ctrl_idle;
    c_inc[4] = BYTES_W'(1);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    prof_id_filter #(.ID_W(ID_W)) u_flt (
      .run(run), .valid(ch_valid[g]), .ready(ch_ready[g]), .id(ch_id[g]),
      .id_sel(id_sel), .id_mask(id_mask), .len(ch_len[g]), .size(ch_size[g]),
      .hit(ch_hit[g]), .bytes(ch_bytes[g])
    );
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    prof_sat_cnt #(.W(CNT_W), .INC_W(BYTES_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(prof_clear), .inc_en(c_en[k]),
      .inc(c_inc[k]), .cnt(c_val[k]), .sat_evt(c_sat[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_flag <= 1'b0;
    else if (prof_clear) ovf_flag <= 1'b0;
    else if (|c_sat)     ovf_flag <= 1'b1;
  end

  assign rd_acc_cnt  = c_val[0];
  assign wr_acc_cnt  = c_val[1];
  assign rd_byte_cnt = c_val[2];
  assign wr_byte_cnt = c_val[3];
  assign busy_cnt    = c_val[4];

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(prof_en && !prof_freeze) && !prof_clear)
    |=> $stable({rd_acc_cnt, wr_acc_cnt, rd_byte_cnt, wr_byte_cnt, busy_cnt})); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !prof_clear) |=> ovf_flag); // R10
  AST_NO_HS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ar_valid && ar_ready) && !prof_clear) |=> $stable(rd_acc_cnt)); // R6
  AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_idle && !prof_clear) |=> $stable(busy_cnt)); // R7
endmodule

// File: tb/sim_prof_mon.sv
`timescale 1ns/100ps
module sim_prof_mon;
  localparam int ID_W = 4;
  localparam int CW   = 16;
  localparam longint MAXV = (64'd1 << CW) - 1;

  typedef struct {
    longint rda, wra, rdb, wrb, busy;
    bit     ovf;
    string  tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic en = 0, frz = 0, clr = 0;
  logic [ID_W-1:0] sel = 0, msk = 0;
  logic arv = 0, arr = 0, awv = 0, awr = 0, idle = 1;
  logic [ID_W-1:0] arid = 0, awid = 0;
  logic [7:0] arlen = 0, awlen = 0;
  logic [2:0] arsz = 0, awsz = 0;
  logic [CW-1:0] rda, wra, rdb, wrb, busy;
  logic ovf;

  int checks = 0, fails = 0;
  exp_t q[$];
  exp_t m;

  always #2.5 clk = ~clk;

  prof_mon #(.ID_W(ID_W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .prof_en(en), .prof_freeze(frz), .prof_clear(clr),
    .id_sel(sel), .id_mask(msk),
    .ar_valid(arv), .ar_ready(arr), .ar_id(arid), .ar_len(arlen), .ar_size(arsz),
    .aw_valid(awv), .aw_ready(awr), .aw_id(awid), .aw_len(awlen), .aw_size(awsz),
    .ctrl_idle(idle),
    .rd_acc_cnt(rda), .wr_acc_cnt(wra), .rd_byte_cnt(rdb), .wr_byte_cnt(wrb),
    .busy_cnt(busy), .ovf_flag(ovf)
  );

  function automatic void add(ref longint c, input longint v, ref bit o);
    if (c + v > MAXV) begin c = MAXV; o = 1; end
    else c = c + v;
  endfunction

  // driver: inputs already set; model the coming edge and push expectation
  task automatic tick(input string tag);
    bit run;
    longint b;
    run = en && !frz;
    if (clr) begin
      m.rda = 0; m.wra = 0; m.rdb = 0; m.wrb = 0; m.busy = 0; m.ovf = 0;
    end else if (run) begin
      if (arv && arr && (((arid ^ sel) & msk) == 0)) begin
        b = (longint'(arlen) + 1) << arsz;
        add(m.rda, 1, m.ovf); add(m.rdb, b, m.ovf);
      end
      if (awv && awr && (((awid ^ sel) & msk) == 0)) begin
        b = (longint'(awlen) + 1) << awsz;
        add(m.wra, 1, m.ovf); add(m.wrb, b, m.ovf);
      end
      if (!idle) add(m.busy, 1, m.ovf);
    end
    m.tag = tag;
    q.push_back(m);
    @(negedge clk);
  endtask

  task automatic idle_bus();
    arv = 0; arr = 0; awv = 0; awr = 0; clr = 0;
  endtask

  // monitor: pop and compare after each edge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      checks++;
      if (rda !== CW'(e.rda) || wra !== CW'(e.wra) || rdb !== CW'(e.rdb) ||
          wrb !== CW'(e.wrb) || busy !== CW'(e.busy) || ovf !== e.ovf) begin
        fails++;
        $display("FAIL %s: got rda=%0d wra=%0d rdb=%0d wrb=%0d busy=%0d ovf=%0d exp rda=%0d wra=%0d rdb=%0d wrb=%0d busy=%0d ovf=%0d",
          e.tag, rda, wra, rdb, wrb, busy, ovf, e.rda, e.wra, e.rdb, e.wrb, e.busy, e.ovf);
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m = '{0, 0, 0, 0, 0, 0, ""};
    #12;
    checks++;
    if (rda !== 0 || wra !== 0 || rdb !== 0 || wrb !== 0 || busy !== 0 || ovf !== 0) begin
      fails++;
      $display("FAIL R1: got nonzero state exp all zero");
    end
    @(negedge clk); rst_n = 1; @(negedge clk);
    sel = 4'h5; msk = 4'hF; en = 1;
    // R2 R4 R7: matching read, 4 beats of 4 bytes
    arv = 1; arr = 1; arid = 5; arlen = 3; arsz = 2; idle = 0;
    tick("R2_R4_R7 read hit");
    // R5: foreign ID ignored
    arid = 6; tick("R5 foreign id");
    // R6: valid without ready
    arid = 5; arr = 0; tick("R6 no ready");
    // R3 R4: write of 1 beat of 8 bytes; R7 idle cycle gives no busy
    idle_bus(); idle = 1;
    awv = 1; awr = 1; awid = 5; awlen = 0; awsz = 3;
    tick("R3_R4 write hit");
    // R8: freeze holds everything
    idle = 0; frz = 1; arv = 1; arr = 1; arid = 5;
    tick("R8 freeze");
    frz = 0; en = 0; tick("R8 disabled");
    // R5: masked group, sel 4 mask E matches id 5
    en = 1; sel = 4'h4; msk = 4'hE; idle_bus(); arv = 1; arr = 1; arid = 5;
    arlen = 1; arsz = 0;
    tick("R5 mask group");
    arid = 7; tick("R5 mask reject");
    msk = 4'h0; arid = 11; tick("R5 zero mask");
    // R9: clear wins over a handshake
    clr = 1; tick("R9 clear");
    clr = 0; idle_bus(); idle = 1;
    // R10: byte saturation, 32768 per burst
    awv = 1; awr = 1; awid = 2; awlen = 8'hFF; awsz = 3'd7;
    tick("R10 first big write");
    tick("R10 saturate");
    tick("R10 hold at max");
    idle_bus(); tick("R10 sticky flag");
    clr = 1; tick("R9 clear flag");
    clr = 0; tick("R1 quiet after clear");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule